// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the slave-side serial command front end of an SPI memory. It takes the chip-select, serial clock, serial data-in and hold pins, brings them into the core clock domain, and assembles bytes with the most significant bit first. The first byte of every selection is the opcode. Any address bytes that follow are collected before a decoded command is handed to the internal logic as a one-cycle strobe carrying the opcode and the address. The block owns the write-enable latch. It also streams the status byte on the serial output, with a separate output-enable that stands in for the tri-state control.

The core logic reports a running internal cycle through a busy input. While busy is high, every opcode except the status read is dropped. An unknown opcode puts the interface into a frozen state until the next selection. The hold pin pauses a transfer without losing its place, but only when it changes while the serial clock is low. The block works in both clock-idle-low mode (mode 0) and clock-idle-high mode (mode 3). In both modes input data is sampled on the rising clock edge and output data changes on the falling edge.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: After reset, `spi_so_oe`, `cmd_valid` and `wel` are all low.
- R2: Opcodes 0x03 (read), 0x02 (program), 0x20 (sector erase) and 0xD8 (block erase) are followed by three address bytes, MSB first. After the last address bit, exactly one `cmd_valid` pulse presents the opcode on `cmd_opcode` and the 24-bit address on `cmd_addr`. Bytes after that are ignored.
- R3: Opcode 0x06 sets `wel` and opcode 0x04 clears it. Neither produces a `cmd_valid` pulse.
- R4: Opcodes 0x02, 0x20, 0xD8 and 0xC7 need the write-enable latch. With `wel` low they produce no `cmd_valid`.
- R5: Opcode 0xC7 (chip erase) is issued as soon as its opcode byte completes, with `cmd_addr` equal to zero.
- R6: After opcode 0x05, `spi_so_oe` is high. On the falling edges that follow, `spi_so` shifts out the status byte `{stat_upper[5:0], wel, dev_busy}` MSB first, repeating byte after byte until deselection.
- R7: Any opcode other than 0x02, 0x03, 0x04, 0x05, 0x06, 0x20, 0xC7 and 0xD8 issues nothing and keeps `spi_so_oe` low. Later bytes in the same selection are not interpreted, so a following 0x06 does not set `wel`.
- R8: While `dev_busy` is high, every opcode other than 0x05 is ignored: no command is issued and `wel` is not changed. Opcode 0x05 still returns status.
- R9: A falling edge on `dev_busy` clears `wel`.
- R10: A hold begins when `spi_hold_n` goes low while the serial clock is low. While held, `spi_so_oe` is low and clock edges and data-in are ignored. The hold ends when `spi_hold_n` goes high with the clock low, and the transfer then continues from where it stopped.
- R11: A change on `spi_hold_n` while the serial clock is high does not pause the transfer.
- R12: Raising `spi_cs_n` part-way through a byte drops the partial bits. The next selection starts a new opcode.
- R13: Mode 3 (clock idles high) gives the same command results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold request, active low |
| dev_busy | input | 1 | Internal program/erase cycle running |
| stat_upper | input | 6 | Upper six status bits supplied by the core |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial data out driver |
| wel | output | 1 | Write-enable latch |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_opcode | output | 8 | Opcode of the issued command |
| cmd_addr | output | 24 | Address of the issued command |

## Verification
Each pin passes through a two-stage synchronizer and one edge register, so a serial edge acts on internal state three to four core cycles later. The serial output settles about five cycles after a falling edge. `cmd_valid` and `wel` change about six cycles after the rising edge that completes a byte. The bench holds each serial clock phase for eight core cycles and samples `spi_so` and `spi_so_oe` at the end of the low phase, just before it raises the clock. After deselection it waits thirty-two cycles before it reads the command record or `wel`. A monitor counts every `cmd_valid` pulse, so a missing pulse or an extra one shows up as a change in that count.

// File: rtl/spi_fe_pkg.sv
// Package: shared opcode codes, decoder state type and opcode class helpers
// for the serial command front end. Assumes 8-bit opcodes and data bytes.
package spi_fe_pkg;

    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_SERASE = 8'h20;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_BERASE = 8'hD8;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_SWALLOW,
        ST_STAT,
        ST_IGNORE
    } fe_state_t;

    // True for opcodes that may only run with the write-enable latch set
    function automatic logic needs_wel(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_SERASE) ||
               (op == OP_BERASE) || (op == OP_CERASE);
    endfunction

    // True for opcodes followed by address bytes
    function automatic logic has_addr(input logic [7:0] op);
        return (op == OP_READ) || (op == OP_PROG) ||
               (op == OP_SERASE) || (op == OP_BERASE);
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
// Module: multi-stage synchronizer with edge detection for a bundle of
// asynchronous pins. Assumes the pins change slowly relative to clk.
// Reset values come from RST_VAL so idle levels produce no false edges.
module spi_fe_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else if (g == 0) chain[g] <= raw;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Purpose: hold last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/spi_fe_shift.sv
// Module: bit-level engine. Tracks the hold state and assembles input bytes
// MSB first on qualified rising edges. Shifts the transmit byte out MSB first
// on qualified falling edges. Assumes synchronized pins and one-cycle edge pulses.
module spi_fe_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              hold_s,
    input  logic              si_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              freeze,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              held,
    output logic              so,
    output logic              so_oe
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W-1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  tx_idx;
    logic [BYTE_W-1:0] snap;
    logic              rise_en;
    logic              fall_en;

    assign rise_en = sck_rise & ~held & ~cs_s & ~freeze;
    assign fall_en = sck_fall & ~held & ~cs_s;

    // Purpose: enter and leave hold, only while the serial clock is low
    always_ff @(posedge clk) begin
        if (!rst_n)                     held <= 1'b0;
        else if (cs_s)                  held <= 1'b0;
        else if (!held && !hold_s && !sck_s) held <= 1'b1;
        else if (held && hold_s && !sck_s)   held <= 1'b0;
    end

    // Purpose: receive shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (rise_en) begin
                shreg   <= {shreg[BYTE_W-2:0], si_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    byte_valid <= 1'b1;
                    byte_data  <= {shreg[BYTE_W-2:0], si_s};
                    bit_cnt    <= '0;
                end
            end
        end
    end

    // Purpose: transmit path, snapshot at byte start, one bit per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_idx <= '0;
            snap   <= '0;
            so     <= 1'b0;
        end else if (!tx_en) begin
            tx_idx <= '0;
        end else if (fall_en) begin
            tx_idx <= (tx_idx == LAST_BIT) ? '0 : tx_idx + 1'b1;
            if (tx_idx == '0) begin
                snap <= tx_byte;
                so   <= tx_byte[BYTE_W-1];
            end else begin
                so   <= snap[LAST_BIT - tx_idx];
            end
        end
    end

    assign so_oe = tx_en & ~held & ~cs_s;

    // R10: the bit position is kept while held
    a_r10_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_s) |=> $stable(bit_cnt));

    // R10: a hold only starts while the clock is low
    a_r10_hold_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(sck_s));

    // R11: a hold ends only while the clock is low (or on deselection)
    a_r11_hold_exit_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held) && !$past(cs_s)) |-> !$past(sck_s));

    // R12: deselection empties the bit counter
    a_r12_cs_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_fe_decode.sv
// Module: byte-level command decoder. Classifies the opcode, collects the
// address, issues commands, filters commands while busy and owns the
// write-enable latch. Assumes byte_valid is a one-cycle pulse per byte.
module spi_fe_decode
    import spi_fe_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_s,
    input  logic                    busy,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    output logic                    freeze,
    output logic                    tx_en,
    output logic                    wel,
    output logic                    cmd_valid,
    output logic [7:0]              cmd_opcode,
    output logic [8*ADDR_BYTES-1:0] cmd_addr
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int ACNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [ACNT_W-1:0] LAST_ADDR = ACNT_W'(ADDR_BYTES - 1);

    fe_state_t         state;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ACNT_W-1:0] addr_cnt;
    logic              busy_q;

    // Purpose: command sequencing, issue strobe and write-enable latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OPC;
            op_q       <= '0;
            addr_q     <= '0;
            addr_cnt   <= '0;
            busy_q     <= 1'b0;
            wel        <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
        end else begin
            busy_q    <= busy;
            cmd_valid <= 1'b0;
            if (cs_s) begin
                state    <= ST_OPC;
                addr_cnt <= '0;
            end else if (byte_valid) begin
                case (state)
                    ST_OPC: begin
                        op_q     <= byte_data;
                        addr_cnt <= '0;
                        if (busy && byte_data != OP_RDSR) begin
                            state <= ST_IGNORE;
                        end else if (byte_data == OP_RDSR) begin
                            state <= ST_STAT;
                        end else if (byte_data == OP_WREN) begin
                            wel   <= 1'b1;
                            state <= ST_SWALLOW;
                        end else if (byte_data == OP_WRDI) begin
                            wel   <= 1'b0;
                            state <= ST_SWALLOW;
                        end else if (byte_data == OP_CERASE) begin
                            if (wel) begin
                                cmd_valid  <= 1'b1;
                                cmd_opcode <= byte_data;
                                cmd_addr   <= '0;
                                state      <= ST_SWALLOW;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (has_addr(byte_data)) begin
                            if (needs_wel(byte_data) && !wel) state <= ST_IGNORE;
                            else                              state <= ST_ADDR;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                    ST_ADDR: begin
                        addr_q   <= {addr_q[ADDR_W-9:0], byte_data};
                        addr_cnt <= addr_cnt + 1'b1;
                        if (addr_cnt == LAST_ADDR) begin
                            if (!busy && (wel || !needs_wel(op_q))) begin
                                cmd_valid  <= 1'b1;
                                cmd_opcode <= op_q;
                                cmd_addr   <= {addr_q[ADDR_W-9:0], byte_data};
                            end
                            state <= ST_SWALLOW;
                        end
                    end
                    default: ;
                endcase
            end
            if (busy_q && !busy) wel <= 1'b0;
        end
    end

    assign freeze = (state == ST_IGNORE);
    assign tx_en  = (state == ST_STAT);

    // R2: a command strobe lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R4: a write-class command leaves only with the latch set
    a_r4_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && needs_wel(cmd_opcode)) |-> $past(wel));

    // R8: no command leaves while the core is busy
    a_r8_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(busy));

    // R9: the end of a busy period drops the latch
    a_r9_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy) |=> !wel);

endmodule

// File: rtl/spi_flash_cmd_front.sv
// Module: top of the serial command front end. Synchronizes the pins,
// runs the bit engine and the command decoder, and builds the status byte.
// Assumes clk is at least eight times faster than the serial clock.
module spi_flash_cmd_front #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_BYTES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_cs_n,
    input  logic                    spi_sck,
    input  logic                    spi_si,
    input  logic                    spi_hold_n,
    input  logic                    dev_busy,
    input  logic [5:0]              stat_upper,
    output logic                    spi_so,
    output logic                    spi_so_oe,
    output logic                    wel,
    output logic                    cmd_valid,
    output logic [7:0]              cmd_opcode,
    output logic [8*ADDR_BYTES-1:0] cmd_addr
);

    localparam int PIN_N = 4;
    localparam int P_CS = 0, P_SCK = 1, P_SI = 2, P_HOLD = 3;
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
    logic             byte_valid, freeze, tx_en, held;
    logic [7:0]       byte_data;
    logic [7:0]       status_byte;

    spi_fe_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({spi_hold_n, spi_si, spi_sck, spi_cs_n}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign status_byte = {stat_upper, wel, dev_busy};

    spi_fe_shift #(.BYTE_W(8)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pin_lvl[P_CS]),
        .sck_s     (pin_lvl[P_SCK]),
        .hold_s    (pin_lvl[P_HOLD]),
        .si_s      (pin_lvl[P_SI]),
        .sck_rise  (pin_rise[P_SCK]),
        .sck_fall  (pin_fall[P_SCK]),
        .freeze    (freeze),
        .tx_en     (tx_en),
        .tx_byte   (status_byte),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .held      (held),
        .so        (spi_so),
        .so_oe     (spi_so_oe)
    );

    spi_fe_decode #(.ADDR_BYTES(ADDR_BYTES)) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pin_lvl[P_CS]),
        .busy      (dev_busy),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .freeze    (freeze),
        .tx_en     (tx_en),
        .wel       (wel),
        .cmd_valid (cmd_valid),
        .cmd_opcode(cmd_opcode),
        .cmd_addr  (cmd_addr)
    );

    // R7: a frozen interface never drives the output
    a_r7_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !spi_so_oe);

    // R10: the output driver is off while held
    a_r10_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !spi_so_oe);

    // Unused edge flags
    logic unused_edges;
    assign unused_edges = ^{pin_rise[P_CS], pin_rise[P_SI], pin_rise[P_HOLD],
                            pin_fall[P_CS], pin_fall[P_SI], pin_fall[P_HOLD]};

endmodule

// File: tb/spi_flash_cmd_front_tb.sv
module spi_flash_cmd_front_tb_top;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_si = 1'b0;
    logic        spi_hold_n = 1'b1;
    logic        dev_busy = 1'b0;
    logic [5:0]  stat_upper = 6'b0;
    logic        spi_so, spi_so_oe, wel, cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;

    int checks = 0;
    int fails  = 0;
    int cmd_cnt = 0;
    logic [7:0]  last_op = 8'h00;
    logic [23:0] last_addr = 24'h0;
    logic        mode3 = 1'b0;
    logic        oe_all;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_cmd_front dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_hold_n(spi_hold_n), .dev_busy(dev_busy),
        .stat_upper(stat_upper), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .wel(wel), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr)
    );

    // Command monitor at the ports
    always @(posedge clk) begin
        if (rst_n && cmd_valid) begin
            cmd_cnt   <= cmd_cnt + 1;
            last_op   <= cmd_opcode;
            last_addr <= cmd_addr;
        end
    end

    // Vector: {pre_wren, busy, opcode, addr, exp_issue, exp_wel}
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h03, 24'h012345, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h02, 24'h00FF00, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h02, 24'h001111, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h20, 24'h01F000, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'hD8, 24'h008000, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'hC7, 24'h000000, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h5A, 24'h000000, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h03, 24'h00ABCD, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h06, 24'h000000, 1'b0, 1'b1},
        {1'b0, 1'b1, 8'h06, 24'h000000, 1'b0, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        spi_sck = mode3;
        wait_clk(H);
        spi_cs_n = 1'b0;
        wait_clk(H);
        oe_all = 1'b1;
    endtask

    task automatic desel();
        if (!mode3) begin
            spi_sck = 1'b0;
            wait_clk(H);
        end
        spi_cs_n = 1'b1;
        wait_clk(4*H);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            spi_sck = 1'b0;
            spi_si  = tx[i];
            wait_clk(H);
            rx[i]   = spi_so;
            oe_all  = oe_all & spi_so_oe;
            spi_sck = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        send_bits(tx, 8, rx);
    endtask

    task automatic txn4(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] rx;
        sel();
        xfer(op, rx);
        xfer(a[23:16], rx);
        xfer(a[15:8], rx);
        xfer(a[7:0], rx);
        desel();
    endtask

    task automatic txn1(input logic [7:0] op);
        logic [7:0] rx;
        sel();
        xfer(op, rx);
        desel();
    endtask

    task automatic toggle_sck(input int n);
        for (int i = 0; i < n; i++) begin
            spi_si  = ~spi_si;
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
            wait_clk(H);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int c0;
        wait_clk(10);
        // R1: reset state
        chk(spi_so_oe == 1'b0, "R1 so_oe", 32'(spi_so_oe), 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 0);
        chk(wel == 1'b0, "R1 wel", 32'(wel), 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk(spi_so_oe == 1'b0 && wel == 1'b0, "R1 after release", 32'({spi_so_oe, wel}), 0);

        // Table walk: R2 R3 R4 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            dev_busy = 1'b0;
            wait_clk(4);
            txn1(8'h04);
            if (VEC[v][35]) txn1(8'h06);
            dev_busy = VEC[v][34];
            wait_clk(4);
            c0 = cmd_cnt;
            txn4(VEC[v][33:26], VEC[v][25:2]);
            chk((cmd_cnt - c0) == int'(VEC[v][1]), "R2/R4/R7/R8 issue count",
                32'(cmd_cnt - c0), 32'(VEC[v][1]));
            if (VEC[v][1]) begin
                chk(last_op == VEC[v][33:26], "R2/R5 opcode", 32'(last_op), 32'(VEC[v][33:26]));
                chk(last_addr == VEC[v][25:2], "R2/R5 address", 32'(last_addr), 32'(VEC[v][25:2]));
            end
            chk(wel == VEC[v][0], "R3/R8 latch", 32'(wel), 32'(VEC[v][0]));
        end
        dev_busy = 1'b0;
        wait_clk(4);

        // R9: busy falling clears the latch
        txn1(8'h06);
        chk(wel == 1'b1, "R3 wren sets", 32'(wel), 1);
        dev_busy = 1'b1;
        wait_clk(6);
        dev_busy = 1'b0;
        wait_clk(6);
        chk(wel == 1'b0, "R9 busy fall clears", 32'(wel), 0);

        // R6 + R10: status stream with a hold between bytes
        txn1(8'h06);
        stat_upper = 6'b101101;
        sel();
        xfer(8'h05, rx);
        oe_all = 1'b1;
        xfer(8'h00, rx);
        chk(rx == 8'hB6, "R6 status byte 1", 32'(rx), 32'hB6);
        chk(oe_all == 1'b1, "R6 oe during status", 32'(oe_all), 1);
        spi_sck = 1'b0;
        wait_clk(H);
        spi_hold_n = 1'b0;
        wait_clk(H);
        chk(spi_so_oe == 1'b0, "R10 oe low while held", 32'(spi_so_oe), 0);
        toggle_sck(3);
        spi_hold_n = 1'b1;
        wait_clk(H);
        oe_all = 1'b1;
        xfer(8'h00, rx);
        chk(rx == 8'hB6, "R10 status after hold", 32'(rx), 32'hB6);
        chk(oe_all == 1'b1, "R10 oe after resume", 32'(oe_all), 1);
        desel();

        // R8: status read still works while busy
        txn1(8'h04);
        stat_upper = 6'b000000;
        dev_busy = 1'b1;
        wait_clk(4);
        sel();
        xfer(8'h05, rx);
        xfer(8'h00, rx);
        chk(rx == 8'h01, "R8 status while busy", 32'(rx), 32'h01);
        desel();
        dev_busy = 1'b0;
        wait_clk(4);

        // R10: hold in the middle of the address, SCK toggling meanwhile
        c0 = cmd_cnt;
        sel();
        xfer(8'h03, rx);
        xfer(8'h0A, rx);
        spi_sck = 1'b0;
        wait_clk(H);
        spi_hold_n = 1'b0;
        wait_clk(H);
        toggle_sck(4);
        spi_hold_n = 1'b1;
        wait_clk(H);
        xfer(8'h0B, rx);
        xfer(8'h0C, rx);
        desel();
        chk(cmd_cnt - c0 == 1 && last_addr == 24'h0A0B0C, "R10 address across hold",
            32'(last_addr), 32'h0A0B0C);

        // R11: hold pulse while SCK high has no effect
        c0 = cmd_cnt;
        sel();
        xfer(8'h03, rx);
        xfer(8'h00, rx);
        spi_hold_n = 1'b0;
        wait_clk(H);
        spi_hold_n = 1'b1;
        wait_clk(H);
        xfer(8'h07, rx);
        xfer(8'h77, rx);
        desel();
        chk(cmd_cnt - c0 == 1 && last_addr == 24'h000777, "R11 hold with SCK high",
            32'(last_addr), 32'h000777);

        // R7: invalid opcode freezes the rest of the selection
        sel();
        xfer(8'hFF, rx);
        xfer(8'h06, rx);
        chk(oe_all == 1'b0 && spi_so_oe == 1'b0, "R7 so_oe stays low",
            32'(spi_so_oe), 0);
        desel();
        chk(wel == 1'b0, "R7 later byte not decoded", 32'(wel), 0);

        // R12: partial byte dropped on deselection
        sel();
        send_bits(8'h06, 5, rx);
        desel();
        c0 = cmd_cnt;
        txn4(8'h03, 24'h00C0DE);
        chk(cmd_cnt - c0 == 1 && last_op == 8'h03 && last_addr == 24'h00C0DE,
            "R12 fresh opcode after abort", 32'(last_addr), 32'h00C0DE);
        chk(wel == 1'b0, "R12 partial wren ignored", 32'(wel), 0);

        // R13: mode 3
        mode3 = 1'b1;
        spi_sck = 1'b1;
        wait_clk(8);
        txn1(8'h06);
        c0 = cmd_cnt;
        txn4(8'h02, 24'h01ABCD);
        chk(cmd_cnt - c0 == 1 && last_op == 8'h02 && last_addr == 24'h01ABCD,
            "R13 mode 3 program", 32'(last_addr), 32'h01ABCD);
        mode3 = 1'b0;
        spi_sck = 1'b0;
        wait_clk(8);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule